// File: doc/BRIEF.md
# Debug Breakpoint Trigger Unit

This block watches the processor's address bus, data bus and program counter. It raises a trigger when a programmed set of conditions is met. Three conditions are available. An address window condition compares the bus address against two bounds. A data condition compares the bus data against a value under a bit mask. A program-counter condition compares the PC against a value under its own mask. No condition can match in a cycle where the bus-valid strobe is low.

Each condition can be enabled independently for a first level and a second level. In single-level mode the unit fires whenever the first level matches. In two-level mode a first-level match arms the unit, and a later second-level match fires it. A trigger is a one-cycle request on either the halt output or the debug-interrupt output, chosen by an action bit.

Six 32-bit compare registers hold the bounds, values and masks. Two write ports load them: one for the debug channel and one for supervisor software. Writing any of the six registers, or pulsing the clear input, returns the sequencer to idle.

Top module: `dbg_trig_unit`

## Requirements
- R1: After synchronous reset, all six compare registers hold zero, `halt_req` and `irq_req` are low, and `armed` is low.
- R2: A write at index 0..5 loads, in that order, the window low bound, window high bound, data value, data mask, PC value and PC mask, taking effect from the next cycle. A write at index 6 or 7 changes no register and does not disturb the sequencer.
- R3: When both ports write the same index in the same cycle, the debug-channel value is stored. When they write different indices, both values are stored.
- R4: The data condition matches when bus data equals the data value on every bit where the data mask is 1. Bits where the mask is 0 are not compared.
- R5: The PC condition matches when `pc` equals the PC value on every bit where the PC mask is 1. Bits where the mask is 0 are not compared.
- R6: The address condition matches when low ≤ `bus_addr` ≤ high, inclusive and unsigned, with `ctl[2]`=0. With `ctl[2]`=1 it matches when the address is outside that range.
- R7: `ctl[5:3]` enables the PC, data and address conditions (in that bit order, high to low) for level 1, and `ctl[8:6]` does the same for level 2. A level matches only when every condition enabled for it matches in the same cycle. A level with no enabled condition never matches.
- R8: With `ctl[0]`=0 (single-level mode), each cycle with a level-1 match produces a trigger in the following cycle, and `armed` stays low.
- R9: With `ctl[0]`=1 (two-level mode), a level-1 match while idle raises `armed` in the next cycle without a trigger. While armed, a level-2 match produces a trigger in the next cycle and drops `armed`. A level-2 match while idle is ignored.
- R10: A trigger is a one-cycle pulse on `halt_req` when `ctl[1]`=0 and on `irq_req` when `ctl[1]`=1. The two outputs are never high together.
- R11: A cycle with `seq_clr` high, or with a write to index 0..5 on either port, drops `armed` and suppresses any trigger in the next cycle.
- R12: While `bus_valid` is low, no condition matches, so the next cycle shows no trigger and no new arming.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dbg_we | input | 1 | Debug-channel write strobe |
| dbg_idx | input | 3 | Debug-channel register index |
| dbg_wdata | input | 32 | Debug-channel write data |
| sup_we | input | 1 | Supervisor write strobe |
| sup_idx | input | 3 | Supervisor register index |
| sup_wdata | input | 32 | Supervisor write data |
| ctl | input | 9 | Trigger control: mode, action, window sense, level enables |
| seq_clr | input | 1 | Returns the sequencer to idle |
| bus_valid | input | 1 | Qualifies the compare inputs |
| bus_addr | input | 32 | Observed bus address |
| bus_data | input | 32 | Observed bus data |
| pc | input | 32 | Observed program counter |
| halt_req | output | 1 | One-cycle halt request |
| irq_req | output | 1 | One-cycle debug-interrupt request |
| armed | output | 1 | Sequencer is in the armed state |

## Verification
The hardest situation to reach is an armed sequencer that meets a disturbing event. Three such events matter: a clear pulse, a register write, and a write to an unused index that must leave it armed. Each can arrive in the same cycle as a second-level match. The stimulus reaches these cases in a fixed order. It first programs a window and a PC value, then arms with an address hit, and then applies each disturbance alone or together with a PC hit. A long random phase follows, with narrow value ranges so that matches, arming and writes collide often. A behavioural model checks every cycle.

// File: rtl/dbg_trig_pkg.sv
package dbg_trig_pkg;
  localparam int NREG  = 6;
  localparam int IDX_W = 3;
  localparam int CTL_W = 9;
  // register indices
  localparam int RI_LO    = 0;
  localparam int RI_HI    = 1;
  localparam int RI_DVAL  = 2;
  localparam int RI_DMASK = 3;
  localparam int RI_PVAL  = 4;
  localparam int RI_PMASK = 5;
  // control bits
  localparam int CB_TWO  = 0;
  localparam int CB_ACT  = 1;
  localparam int CB_OUT  = 2;
  localparam int CB_L1   = 3;
  localparam int CB_L2   = 6;

  typedef struct packed {
    logic pc;
    logic data;
    logic addr;
  } cond_vec_t;

  typedef enum logic {ST_IDLE = 1'b0, ST_ARMED = 1'b1} seq_state_e;
endpackage

// File: rtl/dbg_trig_regs.sv
module dbg_trig_regs
  import dbg_trig_pkg::*;
#(
  parameter int W = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                dbg_we,
  input  logic [IDX_W-1:0]    dbg_idx,
  input  logic [W-1:0]        dbg_wdata,
  input  logic                sup_we,
  input  logic [IDX_W-1:0]    sup_idx,
  input  logic [W-1:0]        sup_wdata,
  output logic [NREG*W-1:0]   rf_flat,
  output logic                wr_hit
);
  logic [W-1:0] rf [NREG];

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst)
        rf[i] <= '0;
      else if (dbg_we && dbg_idx == IDX_W'(i))
        rf[i] <= dbg_wdata;
      else if (sup_we && sup_idx == IDX_W'(i))
        rf[i] <= sup_wdata;
    end
    assign rf_flat[i*W +: W] = rf[i];
  end

  assign wr_hit = (dbg_we && dbg_idx < IDX_W'(NREG)) ||
                  (sup_we && sup_idx < IDX_W'(NREG));

  // R3: debug channel wins a same-index collision
  a_r3_debug_wins: assert property (@(posedge clk) disable iff (rst)
    (dbg_we && sup_we && dbg_idx == sup_idx && dbg_idx < IDX_W'(NREG))
      |=> rf[$past(dbg_idx)] == $past(dbg_wdata));

  // R2: writes to unused indices leave the file unchanged
  a_r2_spare_idx_ignored: assert property (@(posedge clk) disable iff (rst)
    (!(dbg_we && dbg_idx < IDX_W'(NREG)) && !(sup_we && sup_idx < IDX_W'(NREG)))
      |=> $stable(rf_flat));
endmodule

// File: rtl/dbg_trig_mcmp.sv
module dbg_trig_mcmp #(
  parameter int W = 32
) (
  input  logic [W-1:0] obs,
  input  logic [W-1:0] ref_v,
  input  logic [W-1:0] mask,
  output logic         hit
);
  assign hit = ((obs ^ ref_v) & mask) == '0;
endmodule

// File: rtl/dbg_trig_cond.sv
module dbg_trig_cond
  import dbg_trig_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [NREG*W-1:0] rf_flat,
  input  logic              outside,
  input  logic              bus_valid,
  input  logic [W-1:0]      bus_addr,
  input  logic [W-1:0]      bus_data,
  input  logic [W-1:0]      pc,
  output cond_vec_t         hits
);
  localparam int NMASKED = 2;

  logic [W-1:0] rf    [NREG];
  logic [W-1:0] obs_m [NMASKED];
  logic [NMASKED-1:0] mhit;
  logic in_win;

  for (genvar k = 0; k < NREG; k++) begin : g_unpack
    assign rf[k] = rf_flat[k*W +: W];
  end

  assign obs_m[0] = bus_data;
  assign obs_m[1] = pc;

  for (genvar g = 0; g < NMASKED; g++) begin : g_mcmp
    dbg_trig_mcmp #(.W(W)) u_cmp (
      .obs   (obs_m[g]),
      .ref_v (rf[RI_DVAL + 2*g]),
      .mask  (rf[RI_DVAL + 2*g + 1]),
      .hit   (mhit[g])
    );
  end

  assign in_win = (bus_addr >= rf[RI_LO]) && (bus_addr <= rf[RI_HI]);

  always_comb begin
    hits.addr = bus_valid && (in_win ^ outside);
    hits.data = bus_valid && mhit[0];
    hits.pc   = bus_valid && mhit[1];
  end
endmodule

// File: rtl/dbg_trig_seq.sv
module dbg_trig_seq
  import dbg_trig_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      clr,
  input  logic      two_level,
  input  logic      act_irq,
  input  cond_vec_t en1,
  input  cond_vec_t en2,
  input  cond_vec_t hits,
  output logic      halt_req,
  output logic      irq_req,
  output logic      armed
);
  seq_state_e st_q, st_d;
  logic fire_d;
  logic lvl1, lvl2;

  function automatic logic lvl_match(cond_vec_t en, cond_vec_t h);
    return (en != '0) && ((h & en) == en);
  endfunction

  assign lvl1 = lvl_match(en1, hits);
  assign lvl2 = lvl_match(en2, hits);

  always_comb begin
    st_d   = st_q;
    fire_d = 1'b0;
    if (clr) begin
      st_d = ST_IDLE;
    end else if (!two_level) begin
      st_d   = ST_IDLE;
      fire_d = lvl1;
    end else if (st_q == ST_IDLE) begin
      if (lvl1) st_d = ST_ARMED;
    end else if (lvl2) begin
      st_d   = ST_IDLE;
      fire_d = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= ST_IDLE;
      halt_req <= 1'b0;
      irq_req  <= 1'b0;
    end else begin
      st_q     <= st_d;
      halt_req <= fire_d && !act_irq;
      irq_req  <= fire_d && act_irq;
    end
  end

  assign armed = (st_q == ST_ARMED);

  // R10: at most one request line active
  a_r10_one_request: assert property (@(posedge clk) disable iff (rst)
    $onehot0({halt_req, irq_req}));

  // R11: clear or write empties the sequencer
  a_r11_clear_idles: assert property (@(posedge clk) disable iff (rst)
    clr |=> (!armed && !halt_req && !irq_req));

  // R8: single-level mode never arms
  a_r8_single_no_arm: assert property (@(posedge clk) disable iff (rst)
    !two_level |=> !armed);

  // R9: in two-level mode a trigger needs a prior arm
  a_r9_needs_arm: assert property (@(posedge clk) disable iff (rst)
    (two_level && !armed) |=> (!halt_req && !irq_req));
endmodule

// File: rtl/dbg_trig_unit.sv
module dbg_trig_unit
  import dbg_trig_pkg::*;
#(
  parameter int W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             dbg_we,
  input  logic [IDX_W-1:0] dbg_idx,
  input  logic [W-1:0]     dbg_wdata,
  input  logic             sup_we,
  input  logic [IDX_W-1:0] sup_idx,
  input  logic [W-1:0]     sup_wdata,
  input  logic [CTL_W-1:0] ctl,
  input  logic             seq_clr,
  input  logic             bus_valid,
  input  logic [W-1:0]     bus_addr,
  input  logic [W-1:0]     bus_data,
  input  logic [W-1:0]     pc,
  output logic             halt_req,
  output logic             irq_req,
  output logic             armed
);
  logic [NREG*W-1:0] rf_flat;
  logic              wr_hit;
  cond_vec_t         hits;

  dbg_trig_regs #(.W(W)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .dbg_we    (dbg_we),
    .dbg_idx   (dbg_idx),
    .dbg_wdata (dbg_wdata),
    .sup_we    (sup_we),
    .sup_idx   (sup_idx),
    .sup_wdata (sup_wdata),
    .rf_flat   (rf_flat),
    .wr_hit    (wr_hit)
  );

  dbg_trig_cond #(.W(W)) u_cond (
    .rf_flat   (rf_flat),
    .outside   (ctl[CB_OUT]),
    .bus_valid (bus_valid),
    .bus_addr  (bus_addr),
    .bus_data  (bus_data),
    .pc        (pc),
    .hits      (hits)
  );

  dbg_trig_seq u_seq (
    .clk       (clk),
    .rst       (rst),
    .clr       (seq_clr || wr_hit),
    .two_level (ctl[CB_TWO]),
    .act_irq   (ctl[CB_ACT]),
    .en1       (cond_vec_t'(ctl[CB_L1 +: 3])),
    .en2       (cond_vec_t'(ctl[CB_L2 +: 3])),
    .hits      (hits),
    .halt_req  (halt_req),
    .irq_req   (irq_req),
    .armed     (armed)
  );

  // R12: an unqualified cycle can neither fire nor arm
  a_r12_valid_gate: assert property (@(posedge clk) disable iff (rst)
    (!bus_valid && !armed) |=> (!armed && !halt_req && !irq_req));
endmodule

// File: tb/tb_dbg_trig_unit.sv
module tb_dbg_trig_unit;
  localparam int W = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic dbg_we = 0, sup_we = 0, seq_clr = 0, bus_valid = 0;
  logic [2:0] dbg_idx = 0, sup_idx = 0;
  logic [W-1:0] dbg_wdata = 0, sup_wdata = 0, bus_addr = 0, bus_data = 0, pc = 0;
  logic [8:0] ctl = 0;
  logic halt_req, irq_req, armed;

  always #2 clk = ~clk;

  dbg_trig_unit #(.W(W)) dut (
    .clk(clk), .rst(rst),
    .dbg_we(dbg_we), .dbg_idx(dbg_idx), .dbg_wdata(dbg_wdata),
    .sup_we(sup_we), .sup_idx(sup_idx), .sup_wdata(sup_wdata),
    .ctl(ctl), .seq_clr(seq_clr), .bus_valid(bus_valid),
    .bus_addr(bus_addr), .bus_data(bus_data), .pc(pc),
    .halt_req(halt_req), .irq_req(irq_req), .armed(armed)
  );

  int n_chk = 0;
  int n_fail = 0;

  // behavioural reference
  logic [W-1:0] m_rf [6];
  logic m_armed = 0, m_halt = 0, m_irq = 0;

  function automatic logic lvl(logic [2:0] en, logic a, logic d, logic p);
    if (en == 3'b000) return 1'b0;
    if (en[0] && !a) return 1'b0;
    if (en[1] && !d) return 1'b0;
    if (en[2] && !p) return 1'b0;
    return 1'b1;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 6; i++) m_rf[i] = '0;
      m_armed = 0; m_halt = 0; m_irq = 0;
    end else begin
      logic a, d, p, l1, l2, clrc, fire, inwin;
      inwin = (bus_addr >= m_rf[0]) && (bus_addr <= m_rf[1]);
      a = bus_valid && (ctl[2] ? !inwin : inwin);
      d = bus_valid && (((bus_data ^ m_rf[2]) & m_rf[3]) == 0);
      p = bus_valid && (((pc ^ m_rf[4]) & m_rf[5]) == 0);
      l1 = lvl(ctl[5:3], a, d, p);
      l2 = lvl(ctl[8:6], a, d, p);
      clrc = seq_clr || (dbg_we && dbg_idx < 6) || (sup_we && sup_idx < 6);
      fire = 0;
      if (clrc) m_armed = 0;
      else if (!ctl[0]) begin fire = l1; m_armed = 0; end
      else if (!m_armed) m_armed = l1;
      else if (l2) begin fire = 1; m_armed = 0; end
      m_halt = fire && !ctl[1];
      m_irq  = fire && ctl[1];
      if (sup_we && sup_idx < 6) m_rf[sup_idx] = sup_wdata;
      if (dbg_we && dbg_idx < 6) m_rf[dbg_idx] = dbg_wdata;
    end
  end

  task automatic cyc(input string tag);
    @(posedge clk);
    @(negedge clk);
    n_chk++;
    if (halt_req !== m_halt || irq_req !== m_irq || armed !== m_armed) begin
      n_fail++;
      $display("FAIL %s: got halt=%b irq=%b armed=%b expected halt=%b irq=%b armed=%b",
               tag, halt_req, irq_req, armed, m_halt, m_irq, m_armed);
    end
    dbg_we = 0; sup_we = 0; seq_clr = 0;
  endtask

  task automatic wr(input logic dbg, input logic [2:0] idx, input logic [W-1:0] v, input string tag);
    if (dbg) begin dbg_we = 1; dbg_idx = idx; dbg_wdata = v; end
    else     begin sup_we = 1; sup_idx = idx; sup_wdata = v; end
    cyc(tag);
  endtask

  task automatic bus(input logic v, input logic [W-1:0] a, input logic [W-1:0] d,
                     input logic [W-1:0] p, input string tag);
    bus_valid = v; bus_addr = a; bus_data = d; pc = p;
    cyc(tag);
    bus_valid = 0;
  endtask

  // ctl: {l2_en[2:0], l1_en[2:0], outside, act, two}; en bits {pc,data,addr}
  function automatic logic [8:0] mk(logic [2:0] e2, logic [2:0] e1, logic o, logic act, logic two);
    return {e2, e1, o, act, two};
  endfunction

  bit done = 0;
  initial begin
    #(4 * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    cyc("R1 reset state");
    bus(1, 32'h0, 32'h0, 32'h0, "R1 idle enables");

    // R2 program via debug port
    ctl = mk(3'b000, 3'b001, 0, 0, 0);
    wr(1, 0, 32'h100, "R2 lo");
    wr(1, 1, 32'h1FF, "R2 hi");
    wr(1, 2, 32'h0000AB00, "R2 dval");
    wr(1, 3, 32'h0000FF00, "R2 dmask");
    wr(0, 4, 32'h00004000, "R2 pval sup");
    wr(0, 5, 32'hFFFFF000, "R2 pmask sup");
    wr(1, 6, 32'hDEAD, "R2 spare idx");
    // R6 window edges
    bus(1, 32'h100, 0, 0, "R6 low edge");
    bus(1, 32'h1FF, 0, 0, "R6 high edge");
    bus(1, 32'h200, 0, 0, "R6 above");
    bus(1, 32'h0FF, 0, 0, "R6 below");
    ctl = mk(3'b000, 3'b001, 1, 0, 0);
    bus(1, 32'h0FF, 0, 0, "R6 outside below");
    bus(1, 32'h150, 0, 0, "R6 outside inside");
    cyc("R6 settle");
    // R12 valid gate
    ctl = mk(3'b000, 3'b001, 0, 0, 0);
    bus(0, 32'h150, 0, 0, "R12 invalid");
    cyc("R12 settle");
    // R8 consecutive single-level hits
    bus_valid = 1; bus_addr = 32'h180;
    cyc("R8 hit1"); cyc("R8 hit2"); cyc("R8 hit3");
    bus_valid = 0; cyc("R8 settle");
    // R4 data mask
    ctl = mk(3'b000, 3'b010, 0, 0, 0);
    bus(1, 0, 32'h0012AB34, 0, "R4 masked match");
    bus(1, 0, 32'h0000AC00, 0, "R4 mismatch");
    cyc("R4 settle");
    // R5 PC mask
    ctl = mk(3'b000, 3'b100, 0, 0, 0);
    bus(1, 0, 0, 32'h00004FFC, "R5 masked match");
    bus(1, 0, 0, 32'h00005000, "R5 mismatch");
    cyc("R5 settle");
    // R7 combined conditions
    ctl = mk(3'b000, 3'b011, 0, 0, 0);
    bus(1, 32'h150, 32'h0, 0, "R7 addr only");
    bus(1, 32'h150, 32'hAB00, 0, "R7 both");
    cyc("R7 settle");
    ctl = mk(3'b000, 3'b000, 0, 0, 0);
    bus(1, 32'h150, 32'hAB00, 32'h4000, "R7 none enabled");
    cyc("R7 settle2");
    // R10 interrupt action
    ctl = mk(3'b000, 3'b001, 0, 1, 0);
    bus(1, 32'h150, 0, 0, "R10 irq");
    cyc("R10 settle");
    // R3 collisions
    dbg_we = 1; dbg_idx = 0; dbg_wdata = 32'h300;
    sup_we = 1; sup_idx = 0; sup_wdata = 32'h120;
    cyc("R3 same idx");
    bus(1, 32'h120, 0, 0, "R3 sup value lost");
    bus(1, 32'h1FF, 0, 0, "R3 empty window");
    dbg_we = 1; dbg_idx = 0; dbg_wdata = 32'h100;
    sup_we = 1; sup_idx = 1; sup_wdata = 32'h2FF;
    cyc("R3 diff idx");
    bus(1, 32'h2FF, 0, 0, "R3 both stored");
    cyc("R3 settle");
    // R9 two-level: L1 addr, L2 pc
    ctl = mk(3'b100, 3'b001, 0, 0, 1);
    bus(1, 32'h0, 0, 32'h4000, "R9 L2 while idle");
    bus(1, 32'h150, 0, 0, "R9 arm");
    cyc("R9 hold armed");
    bus(1, 32'h0, 0, 32'h4123, "R9 fire");
    cyc("R9 idle again");
    // R11 clear paths
    bus(1, 32'h150, 0, 0, "R11 arm");
    seq_clr = 1; cyc("R11 clear");
    bus(1, 32'h150, 0, 0, "R11 rearm");
    seq_clr = 1; bus(1, 0, 0, 32'h4000, "R11 clear beats fire");
    bus(1, 32'h150, 0, 0, "R11 rearm2");
    wr(0, 2, 32'hAB00, "R11 write disarms");
    bus(1, 32'h150, 0, 0, "R11 rearm3");
    wr(1, 7, 32'h1, "R2 spare keeps armed");
    dbg_we = 1; dbg_idx = 3; dbg_wdata = 32'hFF00;
    bus(1, 0, 0, 32'h4000, "R11 write beats fire");
    cyc("R11 settle");

    // random mix
    for (int n = 0; n < 3000; n++) begin
      ctl = 9'($urandom);
      bus_valid = ($urandom % 4) != 0;
      bus_addr = 32'($urandom % 32'h400);
      bus_data = {16'($urandom % 2), 8'hAB - 8'($urandom % 2), 8'($urandom)};
      pc = {20'h4 + 20'($urandom % 2), 12'($urandom)};
      seq_clr = ($urandom % 40) == 0;
      if (($urandom % 30) == 0) begin
        dbg_we = 1; dbg_idx = 3'($urandom); dbg_wdata = 32'($urandom % 32'h400);
      end
      if (($urandom % 30) == 0) begin
        sup_we = 1; sup_idx = 3'($urandom); sup_wdata = 32'($urandom % 32'h400);
      end
      cyc("R8 random mix");
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule